// File: doc/BRIEF.md
# PLL Control Register with Lock-Change Interrupt

This block is the 8-bit control and status register of a clock-generator PLL. A CPU reaches it over a simple bus with an address, a read strobe, a write strobe and separate write and read data. The register holds the PLL enable, the base-clock select, a two-bit prescaler, a two-bit VCO range, an interrupt enable and a lock-change flag. Each field drives a matching output pin.

The lock status from the analog loop comes in asynchronously and passes through a synchronizer. Every change of that status, rising or falling, sets the flag. Reading the register clears the flag. An AUTO bandwidth-mode input gates the interrupt enable and the flag. While the VCO clock drives the base clock, software cannot switch the PLL off.

Top module: `pll_ctrl_reg`

## Requirements
- R1: On synchronous reset, every field is 0 except the PLL-on field, which is 1. After reset `irq` is 0 and `bus_rdata` is 0.
- R2: Bit positions in read data and write data: bit 7 is the interrupt enable, bit 6 is the flag, bit 5 is PLL on, bit 4 is clock select, bits 3:2 are the prescaler and bits 1:0 are the VCO range. Read data appears on `bus_rdata` in the cycle after the read strobe. In every other cycle `bus_rdata` is 0.
- R3: A rising or a falling change of `lock_in` sets the flag at the third rising clock edge after the change.
- R4: A read at the register address clears the flag at the clock edge that performs the read.
- R5: If a lock change is detected at the same edge as a clearing read, the flag ends up set.
- R6: `irq` is 1 exactly when the flag, the interrupt enable and `auto_mode` are all 1.
- R7: While `auto_mode` is 0, writes to the interrupt-enable bit are ignored, the enable and flag bits read as 0, and `irq` stays 0.
- R8: A write with bit 5 = 0 leaves PLL on at 1 while clock select is currently 1. The other fields of that write still update.
- R9: Writes to bit 6 have no effect on the flag.
- R10: Reads and writes at any other address change nothing and return 0.
- R11: `pll_enable`, `clk_sel`, `prescale` and `vco_range` always show the stored field values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, 0 when idle |
| lock_in | input | 1 | Asynchronous PLL lock status |
| auto_mode | input | 1 | Automatic bandwidth mode; gates enable and flag |
| irq | output | 1 | Lock-change interrupt request |
| pll_enable | output | 1 | PLL on |
| clk_sel | output | 1 | Base clock taken from the VCO |
| prescale | output | 2 | Prescaler select |
| vco_range | output | 2 | VCO power-of-two range select |

## Verification
Two functions can act on the flag at the same clock edge: setting it on a detected lock change and clearing it on a register read. The bench provokes this by changing `lock_in` and then raising the read strobe so that the read falls on the third edge, the same edge at which detection happens. That read must return the flag as 0, because it samples the value before the edge. A second read must then return the flag as 1, with `irq` high in between. A related timing case pairs a PLL-off write with clock select already at 1, where the write must update every field except PLL on.

// File: rtl/pllcr_pkg.sv
package pllcr_pkg;
  localparam int DATA_W   = 8;
  localparam int PRE_W    = 2;
  localparam int VPR_W    = 2;
  localparam int BIT_IE   = 7;
  localparam int BIT_FLAG = 6;
  localparam int BIT_ON   = 5;
  localparam int BIT_BCS  = 4;
  localparam int PRE_LSB  = 2;
  localparam int VPR_LSB  = 0;

  typedef struct packed {
    logic             ie;
    logic             on;
    logic             bcs;
    logic [PRE_W-1:0] pre;
    logic [VPR_W-1:0] vpr;
  } pllcr_fields_t;

  localparam pllcr_fields_t FIELDS_RST = '{ie: 1'b0, on: 1'b1, bcs: 1'b0,
                                           pre: '0, vpr: '0};
endpackage

// File: rtl/pllcr_lock_sync.sv
module pllcr_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic toggle
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain[STAGES-1];
  end

  assign toggle = chain[STAGES-1] ^ prev_q;
endmodule

// File: rtl/pllcr_event_flag.sv
module pllcr_event_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end
endmodule

// File: rtl/pllcr_field_regs.sv
module pllcr_field_regs
  import pllcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic              auto_mode,
  input  logic [DATA_W-1:0] wdata,
  output pllcr_fields_t     fields
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fields <= FIELDS_RST;
    end else if (wr_hit) begin
      if (auto_mode) fields.ie <= wdata[BIT_IE];
      fields.on  <= wdata[BIT_ON] | fields.bcs;
      fields.bcs <= wdata[BIT_BCS];
      fields.pre <= wdata[PRE_LSB +: PRE_W];
      fields.vpr <= wdata[VPR_LSB +: VPR_W];
    end
  end
endmodule

// File: rtl/pll_ctrl_reg.sv
module pll_ctrl_reg
  import pllcr_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int unsigned REG_ADDR    = 'h90,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              lock_in,
  input  logic              auto_mode,
  output logic              irq,
  output logic              pll_enable,
  output logic              clk_sel,
  output logic [PRE_W-1:0]  prescale,
  output logic [VPR_W-1:0]  vco_range
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

  logic          addr_hit, rd_hit, wr_hit;
  logic          lock_toggle, flag_q;
  pllcr_fields_t fields;
  logic [DATA_W-1:0] rd_word;

  assign addr_hit = (bus_addr == MY_ADDR);
  assign rd_hit   = bus_rd & addr_hit;
  assign wr_hit   = bus_wr & addr_hit;

  pllcr_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(lock_in), .toggle(lock_toggle)
  );

  pllcr_event_flag u_flag (
    .clk(clk), .rst(rst), .set_evt(lock_toggle), .clr_req(rd_hit), .flag(flag_q)
  );

  pllcr_field_regs u_fields (
    .clk(clk), .rst(rst), .wr_hit(wr_hit), .auto_mode(auto_mode),
    .wdata(bus_wdata), .fields(fields)
  );

  always_comb begin
    rd_word                     = '0;
    rd_word[BIT_IE]             = fields.ie & auto_mode;
    rd_word[BIT_FLAG]           = flag_q & auto_mode;
    rd_word[BIT_ON]             = fields.on;
    rd_word[BIT_BCS]            = fields.bcs;
    rd_word[PRE_LSB +: PRE_W]   = fields.pre;
    rd_word[VPR_LSB +: VPR_W]   = fields.vpr;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_hit ? rd_word : '0;
  end

  assign irq        = flag_q & fields.ie & auto_mode;
  assign pll_enable = fields.on;
  assign clk_sel    = fields.bcs;
  assign prescale   = fields.pre;
  assign vco_range  = fields.vpr;
endmodule

// File: rtl/pllcr_checker.sv
module pllcr_checker #(
  parameter int          ADDR_W   = 8,
  parameter int unsigned REG_ADDR = 'h90
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [7:0]        bus_rdata,
  input logic              auto_mode,
  input logic              irq,
  input logic              pll_enable,
  input logic              clk_sel,
  input logic              lock_toggle,
  input logic              flag_q
);
  logic hit;
  assign hit = (bus_addr == ADDR_W'(REG_ADDR));

  // R10
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && hit) |=> (bus_rdata == 8'h00));

  // R4
  read_clears_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && hit && !lock_toggle) |=> !flag_q);

  // R5
  toggle_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    lock_toggle |=> flag_q);

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!lock_toggle && !(bus_rd && hit)) |=> $stable(flag_q));

  // R8
  on_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && hit && clk_sel) |=> pll_enable);

  // R7
  auto_off_irq_chk: assert property (@(posedge clk) disable iff (rst)
    !auto_mode |-> !irq);

  // R7
  auto_off_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && hit && !auto_mode) |=> (bus_rdata[7:6] == 2'b00));
endmodule

bind pll_ctrl_reg pllcr_checker #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .auto_mode(auto_mode), .irq(irq),
  .pll_enable(pll_enable), .clk_sel(clk_sel),
  .lock_toggle(lock_toggle), .flag_q(flag_q)
);

// File: tb/test_pll_ctrl_reg.sv
module test_pll_ctrl_reg;
  localparam logic [7:0] RA = 8'h90;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       lock_in = 1'b0, auto_mode = 1'b1;
  logic       irq, pll_enable, clk_sel;
  logic [1:0] prescale, vco_range;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pll_ctrl_reg i_pll_ctrl_reg (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_in(lock_in),
    .auto_mode(auto_mode), .irq(irq), .pll_enable(pll_enable),
    .clk_sel(clk_sel), .prescale(prescale), .vco_range(vco_range)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  // change lock at a negedge and wait until the flag has been set (3 edges)
  task automatic flip_lock();
    @(negedge clk); lock_in = ~lock_in;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 rdata", bus_rdata, 8'h00);
    check("R11 outputs", {pll_enable, clk_sel, prescale, vco_range, 2'b00}, 8'h80);
    rd(RA, d); check("R1 R2 reset readback", d, 8'h20);
    @(negedge clk); check("R2 rdata idle", bus_rdata, 8'h00);
  endtask

  task automatic t_fields();
    logic [7:0] d;
    wr(RA, 8'hAF); rd(RA, d); check("R2 field readback", d, 8'hAF);
    check("R11 prescale/vco", {4'd0, prescale, vco_range}, 8'h0F);
    wr(RA, 8'h1A); rd(RA, d); check("R2 clear on, set bcs", d, 8'h1A);
    check("R11 enable/sel", {6'd0, pll_enable, clk_sel}, 8'h01);
  endtask

  task automatic t_on_hold();
    logic [7:0] d;
    wr(RA, 8'h30);
    wr(RA, 8'h05); rd(RA, d); check("R8 on held, others update", d, 8'h25);
    check("R8 pll_enable", {7'd0, pll_enable}, 8'h01);
    wr(RA, 8'h05); rd(RA, d); check("R8 on clears once bcs=0", d, 8'h05);
  endtask

  task automatic t_flag();
    logic [7:0] d;
    wr(RA, 8'hA0);
    @(negedge clk); lock_in = 1'b1;
    repeat (2) @(negedge clk); check("R3 not yet set", {7'd0, irq}, 8'h00);
    @(negedge clk); check("R3 R6 rise sets irq", {7'd0, irq}, 8'h01);
    rd(RA, d); check("R2 flag read", d, 8'hE0);
    check("R4 irq after read", {7'd0, irq}, 8'h00);
    rd(RA, d); check("R4 flag cleared", d, 8'hA0);
    flip_lock(); check("R3 fall sets irq", {7'd0, irq}, 8'h01);
    rd(RA, d); check("R3 fall flag read", d, 8'hE0);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    @(negedge clk); lock_in = ~lock_in;
    repeat (2) @(negedge clk);
    bus_addr = RA; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    check("R5 read at set edge", d, 8'hA0);
    check("R5 irq kept", {7'd0, irq}, 8'h01);
    rd(RA, d); check("R5 flag survived", d, 8'hE0);
  endtask

  task automatic t_flag_write();
    logic [7:0] d;
    flip_lock();
    wr(RA, 8'h20); rd(RA, d); check("R9 write 0 keeps flag", d, 8'h60);
    wr(RA, 8'h60); rd(RA, d); check("R9 write 1 no set", d, 8'h20);
  endtask

  task automatic t_auto();
    logic [7:0] d;
    auto_mode = 1'b0;
    wr(RA, 8'hA0);
    flip_lock(); check("R7 irq off", {7'd0, irq}, 8'h00);
    rd(RA, d); check("R7 masked read", d, 8'h20);
    auto_mode = 1'b1;
    rd(RA, d); check("R7 ie write ignored", d, 8'h20);
    wr(RA, 8'hA0);
    auto_mode = 1'b0;
    rd(RA, d); check("R7 ie masked", d, 8'h20);
    auto_mode = 1'b1;
    rd(RA, d); check("R7 ie kept", d, 8'hA0);
  endtask

  task automatic t_addr();
    logic [7:0] d;
    wr(8'h91, 8'h1F); rd(RA, d); check("R10 foreign write", d, 8'hA0);
    flip_lock();
    rd(8'h91, d); check("R10 foreign read data", d, 8'h00);
    check("R10 flag not cleared", {7'd0, irq}, 8'h01);
    rd(RA, d); check("R10 flag still set", d, 8'hE0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fields();
    t_on_hold();
    t_flag();
    t_collision();
    t_flag_write();
    t_auto();
    t_addr();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule